// File: doc/BRIEF.md
# SPI Interrupt and DMA Request Unit

This block gathers the event pulses of an SPI controller into latched status flags and merges the enabled flags into a single interrupt line. It also drives the transmit and receive DMA request lines from the live FIFO levels. The FIFO storage and the serial engine sit outside it and provide the event pulses, the levels and the thresholds.

Software reaches the block through a simple strobe register bus with two addresses. The enable word is at address 0. The status view is at address 1: a read returns the flags, and a write there is a clear command, with a 1 clearing the matching flag. The enable word has five bits. Three of them gate interrupt sources. The other two, bit 2 and bit 1, gate the transmit and receive DMA requests and never reach the interrupt line.

Every pin is a plain level or a single-cycle pulse, because no data stream passes through the block. There is therefore no valid/ready pair and no back-pressure. A read strobe gives registered read data one cycle later.

Top module: `spi_irq_unit`

## Requirements
- R1: After reset the enable word is 0, all latched flags are 0, and `irq`, `tx_dma_req`, `rx_dma_req` and `rx_batch_ready` are low.
- R2: A write to address 0 loads the enable word from `reg_wdata[4:0]`. Reading address 0 returns that word with bits above 4 reading as 0.
- R3: A one-cycle pulse on `ev_rx_ovf`, `ev_rx_done` or `ev_tx_done` sets status bit 0, 3 or 4 respectively from the next cycle. The bit stays set until it is cleared.
- R4: A write to address 1 clears each of status bits 0, 3 and 4 whose `reg_wdata` bit is 1. Zero bits and all other bit positions have no effect, and the enable word is not changed.
- R5: When an event pulse arrives in the same cycle as a write that clears its flag, the flag stays set.
- R6: Status bit 9 reads 1 exactly while `rx_level >= rx_thresh`. This bit is not latched, and it is not cleared by writes.
- R7: `irq` is high exactly when some latched flag among bits 0, 3 and 4 is set and the enable bit at the same position is set. Status bit 9 and enable bits 1 and 2 never raise it.
- R8: `tx_dma_req` is high exactly while enable bit 2 is set and `tx_level <= tx_thresh`.
- R9: `rx_dma_req` is high exactly while enable bit 1 is set and `rx_level >= rx_thresh`.
- R10: `rx_batch_ready` is high exactly when the receive-complete flag (status bit 3) is set and status bit 9 is set.
- R11: Read data appears on `reg_rdata` in the cycle after a `reg_rd` strobe and holds until the next strobe. Reads of any address other than 0 or 1 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Registered read data |
| ev_tx_done | input | 1 | Transmit-complete event pulse |
| ev_rx_done | input | 1 | Receive-complete event pulse |
| ev_rx_ovf | input | 1 | Receive overrun event pulse |
| tx_level | input | LVL_W | Transmit FIFO fill level |
| tx_thresh | input | LVL_W | Transmit DMA threshold |
| rx_level | input | LVL_W | Receive FIFO fill level |
| rx_thresh | input | LVL_W | Receive threshold |
| irq | output | 1 | Combined interrupt |
| tx_dma_req | output | 1 | Transmit DMA request |
| rx_dma_req | output | 1 | Receive DMA request |
| rx_batch_ready | output | 1 | Receive complete with threshold reached |

## Verification
The bench builds the block with DATA_W = 16 and LVL_W = 4. The 16-bit word leaves room for status bit 9 and for upper bits that must read as zero. The 4-bit levels allow both ends of the comparison range to be driven: level 0 against threshold 0, and level 15 against threshold 15. The bench uses these ranges to test the equal-to-threshold edges of both DMA comparisons. It also tests an event and its clear in the same cycle, and a clear command that names the wrong flag.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;
  // bit positions shared by enable word and status view
  localparam int unsigned POS_ROVR   = 0;
  localparam int unsigned POS_RXDMA  = 1;
  localparam int unsigned POS_TXDMA  = 2;
  localparam int unsigned POS_RXDONE = 3;
  localparam int unsigned POS_TXDONE = 4;
  localparam int unsigned POS_RXTHR  = 9;
  localparam int unsigned EN_W       = 5;
  localparam int unsigned NUM_FLAGS  = 3;

  // latched flag index -> bit position
  function automatic int unsigned flag_pos(input int unsigned idx);
    case (idx)
      0:       flag_pos = POS_ROVR;
      1:       flag_pos = POS_RXDONE;
      default: flag_pos = POS_TXDONE;
    endcase
  endfunction
endpackage

// File: rtl/spi_irq_flag.sv
module spi_irq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)      flag_o <= 1'b0;
    else if (set_i)  flag_o <= 1'b1;   // event beats clear
    else if (clr_i)  flag_o <= 1'b0;
  end

  a_r5_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> flag_o);
  a_r4_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !flag_o);
  a_r3_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_o && !clr_i) |=> flag_o);
endmodule

// File: rtl/spi_irq_dma.sv
module spi_irq_dma #(
  parameter int unsigned LVL_W = 4
) (
  input  logic             tx_en,
  input  logic             rx_en,
  input  logic [LVL_W-1:0] tx_level,
  input  logic [LVL_W-1:0] tx_thresh,
  input  logic [LVL_W-1:0] rx_level,
  input  logic [LVL_W-1:0] rx_thresh,
  output logic             rx_thr_hit,
  output logic             tx_req,
  output logic             rx_req
);
  logic tx_low;
  always_comb begin
    tx_low     = (tx_level <= tx_thresh);
    rx_thr_hit = (rx_level >= rx_thresh);
    tx_req     = tx_en && tx_low;
    rx_req     = rx_en && rx_thr_hit;
  end
endmodule

// File: rtl/spi_irq_regs.sv
module spi_irq_regs
  import spi_irq_pkg::*;
#(
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned ADDR_EN   = 0,
  parameter int unsigned ADDR_STAT = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] status_word,
  output logic [EN_W-1:0]   en_q,
  output logic              stat_wr,
  output logic [DATA_W-1:0] rdata
);
  logic hit_en, hit_stat;
  logic [DATA_W-1:0] rd_mux;

  always_comb begin
    hit_en   = (addr == ADDR_W'(ADDR_EN));
    hit_stat = (addr == ADDR_W'(ADDR_STAT));
    stat_wr  = wr && hit_stat;
    rd_mux   = '0;
    if (hit_en)        rd_mux[EN_W-1:0] = en_q;
    else if (hit_stat) rd_mux = status_word;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)            en_q <= '0;
    else if (wr && hit_en) en_q <= wdata[EN_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)  rdata <= '0;
    else if (rd) rdata <= rd_mux;
  end

  a_r11_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> $stable(rdata));
  a_r4_stat_write_keeps_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !hit_en) |=> $stable(en_q));
endmodule

// File: rtl/spi_irq_unit.sv
module spi_irq_unit
  import spi_irq_pkg::*;
#(
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned LVL_W     = 4,
  parameter int unsigned ADDR_EN   = 0,
  parameter int unsigned ADDR_STAT = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              ev_tx_done,
  input  logic              ev_rx_done,
  input  logic              ev_rx_ovf,
  input  logic [LVL_W-1:0]  tx_level,
  input  logic [LVL_W-1:0]  tx_thresh,
  input  logic [LVL_W-1:0]  rx_level,
  input  logic [LVL_W-1:0]  rx_thresh,
  output logic              irq,
  output logic              tx_dma_req,
  output logic              rx_dma_req,
  output logic              rx_batch_ready
);
  localparam int unsigned IDX_RXDONE = 1;

  logic [NUM_FLAGS-1:0] ev_vec, flags, en_mask, clr_vec;
  logic [EN_W-1:0]      en_q;
  logic [DATA_W-1:0]    status_word;
  logic                 stat_wr, thr_hit;

  assign ev_vec = {ev_tx_done, ev_rx_done, ev_rx_ovf};

  spi_irq_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ADDR_EN(ADDR_EN), .ADDR_STAT(ADDR_STAT)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .rd(reg_rd), .addr(reg_addr),
    .wdata(reg_wdata), .status_word(status_word), .en_q(en_q),
    .stat_wr(stat_wr), .rdata(reg_rdata)
  );

  for (genvar gi = 0; gi < NUM_FLAGS; gi++) begin : g_flag
    localparam int unsigned P = flag_pos(gi);
    assign clr_vec[gi] = stat_wr && reg_wdata[P];
    assign en_mask[gi] = en_q[P];
    spi_irq_flag u_flag (
      .clk(clk), .rst_n(rst_n), .set_i(ev_vec[gi]),
      .clr_i(clr_vec[gi]), .flag_o(flags[gi])
    );
  end

  spi_irq_dma #(.LVL_W(LVL_W)) u_dma (
    .tx_en(en_q[POS_TXDMA]), .rx_en(en_q[POS_RXDMA]),
    .tx_level(tx_level), .tx_thresh(tx_thresh),
    .rx_level(rx_level), .rx_thresh(rx_thresh),
    .rx_thr_hit(thr_hit), .tx_req(tx_dma_req), .rx_req(rx_dma_req)
  );

  always_comb begin
    status_word = '0;
    for (int i = 0; i < NUM_FLAGS; i++) status_word[flag_pos(i)] = flags[i];
    status_word[POS_RXTHR] = thr_hit;
  end

  assign irq            = |(flags & en_mask);
  assign rx_batch_ready = flags[IDX_RXDONE] && thr_hit;

  a_r7_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (flags != '0));
  a_r8_txreq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    tx_dma_req |-> en_q[POS_TXDMA]);
  a_r9_rxreq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    rx_dma_req |-> en_q[POS_RXDMA]);
  a_r10_batch_needs_threshold: assert property (@(posedge clk) disable iff (!rst_n)
    rx_batch_ready |-> status_word[POS_RXTHR]);
endmodule

// File: tb/spi_irq_unit_tb.sv
module spi_irq_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 4, DW = 16, LW = 4;

  logic clk = 0, rst_n = 0;
  logic reg_wr = 0, reg_rd = 0;
  logic [AW-1:0] reg_addr = '0;
  logic [DW-1:0] reg_wdata = '0, reg_rdata;
  logic ev_tx_done = 0, ev_rx_done = 0, ev_rx_ovf = 0;
  logic [LW-1:0] tx_level = '0, tx_thresh = '0, rx_level = '0, rx_thresh = 4'd1;
  logic irq, tx_dma_req, rx_dma_req, rx_batch_ready;

  int n_vec = 0, n_bad = 0;
  logic [DW-1:0] exp_q[$];
  string tag_q[$];
  logic rd_seen = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_irq_unit #(.ADDR_W(AW), .DATA_W(DW), .LVL_W(LW)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ev_tx_done(ev_tx_done), .ev_rx_done(ev_rx_done), .ev_rx_ovf(ev_rx_ovf),
    .tx_level(tx_level), .tx_thresh(tx_thresh), .rx_level(rx_level),
    .rx_thresh(rx_thresh), .irq(irq), .tx_dma_req(tx_dma_req),
    .rx_dma_req(rx_dma_req), .rx_batch_ready(rx_batch_ready)
  );

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: pop one expected read per issued strobe
  always @(posedge clk) rd_seen <= reg_rd;
  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) begin
        n_vec++; n_bad++;
        $display("FAIL R11: unexpected read data %h expected none", reg_rdata);
      end else begin
        check(tag_q.pop_front(), reg_rdata, exp_q.pop_front());
      end
    end
  end

  task automatic wr(input int a, input logic [DW-1:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = AW'(a); reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input int a, input logic [DW-1:0] exp, input string tag);
    @(negedge clk); reg_rd = 1; reg_addr = AW'(a);
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk); reg_rd = 0;
    @(negedge clk); #1;  // let monitor compare
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    case (which) 0: ev_rx_ovf = 1; 1: ev_rx_done = 1; default: ev_tx_done = 1; endcase
    @(negedge clk); ev_rx_ovf = 0; ev_rx_done = 0; ev_tx_done = 0;
    #1;
  endtask

  task automatic report;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_vec++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    // R1 reset state
    check("R1", {13'd0, irq, tx_dma_req, rx_dma_req}, '0);
    check("R1", {15'd0, rx_batch_ready}, '0);
    rd(0, 16'h0000, "R1");
    rd(1, 16'h0000, "R1");

    // R2 enable load and masking
    wr(0, 16'h001F); rd(0, 16'h001F, "R2");
    wr(0, 16'hFFE5); rd(0, 16'h0005, "R2");
    wr(0, 16'h0000);

    // R3 overrun latches, R7 masked while disabled
    pulse(0);
    rd(1, 16'h0001, "R3");
    check("R7", {15'd0, irq}, 16'd0);
    wr(0, 16'h0001); #1;
    check("R7", {15'd0, irq}, 16'd1);
    wr(0, 16'h0006); #1;
    check("R7", {15'd0, irq}, 16'd0);   // DMA enables do not gate irq
    wr(0, 16'h0001);

    // R4 wrong clear bit keeps flag; right bit clears; enable untouched
    wr(1, 16'hFFF6); rd(1, 16'h0001, "R4");
    wr(1, 16'h0001); rd(1, 16'h0000, "R4");
    check("R4", {15'd0, irq}, 16'd0);
    rd(0, 16'h0001, "R4");

    // R5 event and clear together
    @(negedge clk); reg_wr = 1; reg_addr = AW'(1); reg_wdata = 16'h0008; ev_rx_done = 1;
    @(negedge clk); reg_wr = 0; ev_rx_done = 0;
    rd(1, 16'h0008, "R5");
    wr(1, 16'h0008); rd(1, 16'h0000, "R5");

    // R6 raw threshold bit, not clearable
    rx_level = 4'd5; rx_thresh = 4'd5;
    rd(1, 16'h0200, "R6");
    wr(1, 16'hFFFF); rd(1, 16'h0200, "R6");
    wr(0, 16'h001D); #1;
    check("R7", {15'd0, irq}, 16'd0);  // bit 9 never interrupts
    rx_level = 4'd4; rd(1, 16'h0000, "R6");

    // R9 receive DMA request
    wr(0, 16'h0002);
    rx_level = 4'd5; #1; check("R9", {15'd0, rx_dma_req}, 16'd1);
    rx_level = 4'd4; #1; check("R9", {15'd0, rx_dma_req}, 16'd0);
    rx_level = 4'd15; rx_thresh = 4'd15; #1; check("R9", {15'd0, rx_dma_req}, 16'd1);
    wr(0, 16'h0000); #1; check("R9", {15'd0, rx_dma_req}, 16'd0);

    // R8 transmit DMA request
    wr(0, 16'h0004);
    tx_level = 4'd3; tx_thresh = 4'd3; #1; check("R8", {15'd0, tx_dma_req}, 16'd1);
    tx_level = 4'd4; #1; check("R8", {15'd0, tx_dma_req}, 16'd0);
    tx_level = 4'd0; tx_thresh = 4'd0; #1; check("R8", {15'd0, tx_dma_req}, 16'd1);
    wr(0, 16'h0000); #1; check("R8", {15'd0, tx_dma_req}, 16'd0);

    // R10 receive complete qualified by threshold
    rx_level = 4'd2; rx_thresh = 4'd6;
    pulse(1);
    check("R10", {15'd0, rx_batch_ready}, 16'd0);
    rx_level = 4'd6; #1;
    check("R10", {15'd0, rx_batch_ready}, 16'd1);
    wr(0, 16'h0008); #1;
    check("R7", {15'd0, irq}, 16'd1);

    // R3 transmit complete, combined status
    pulse(2);
    pulse(0);
    rd(1, 16'h0219, "R3");
    wr(0, 16'h0010); #1;
    check("R7", {15'd0, irq}, 16'd1);
    wr(1, 16'h0019); rd(1, 16'h0200, "R4");
    check("R7", {15'd0, irq}, 16'd0);
    check("R10", {15'd0, rx_batch_ready}, 16'd0);

    // R11 unused address reads zero
    rd(2, 16'h0000, "R11");
    rd(15, 16'h0000, "R11");

    repeat (2) @(negedge clk);
    report();
  end
endmodule